// File: doc/BRIEF.md
# Streaming Top-Three and Average Unit

This block watches a burst of unsigned samples and reports four statistics about it: the largest, second-largest and third-largest values in the burst, and their integer mean. A one-cycle `go` request opens a run. On each of the next k clock cycles the block takes the value on `din`, adds it to a running total and, if it beats any of the three ranked values held so far, inserts it at its rank, with the lower ranks moving down one place. The burst length k is a power of two, 2^M, so the mean is the total shifted right by M bits, with no divider.

Once the k-th sample is taken the block raises `done` and holds every result until the next `go`. A 2-bit selector picks which result drives the N-bit output. The selector is a plain combinational choice, so software or a neighbour block can read all four results in turn. Inside, a datapath (ranked registers with three parallel comparators, an adder, a sample counter and the output selector) is steered by a separate three-state controller.

Top module: `stat_top3_avg`

## Requirements
- R1: After synchronous reset, `done` is 0 and `dout` is 0 for every value of `sel`.
- R2: A `go` pulse while no run is active clears the total and the three ranked values to zero and drops `done` at the next clock edge. The first sample is taken on the edge after the `go` edge.
- R3: A run takes exactly k = 2^M samples, one per cycle, on consecutive edges. `done` is 0 until the k-th sample is taken and is 1 from that edge on.
- R4: A sample strictly greater than the largest value becomes the largest. The old largest becomes second and the old second becomes third.
- R5: Otherwise, a sample strictly greater than the second value becomes the second, and the old second becomes third. The largest is unchanged.
- R6: Otherwise, a sample strictly greater than the third value replaces the third. A sample not greater than the third changes no ranked value.
- R7: A sample equal to a ranked value never displaces that value. Repeated values can therefore occupy several ranks.
- R8: `sel` = 0 selects the largest value, 1 the second, 2 the third and 3 the average.
- R9: The average is floor(sum of the k samples / k). The total is N+M bits wide, so k samples of the maximum value give an average equal to that maximum.
- R10: While `done` is 1 and `go` is 0, `done` and all results stay unchanged whatever `din` does. A `go` that arrives during a run is ignored.
- R11: A reset asserted in the middle of a run abandons it. `done` is 0 and every result is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, one cycle |
| din | input | N | Sample stream, one sample per cycle during a run |
| sel | input | 2 | Result selector: 0 largest, 1 second, 2 third, 3 average |
| done | output | 1 | High once the run is complete, until the next start |
| dout | output | N | Selected result |

## Verification
The ranked insertion is driven with ascending, descending, all-equal (zero and maximum) and interleaved bursts. Ascending and descending bursts separate the shift-down path from the no-change path. Bursts with repeated values check the strict comparison and the way ties fill lower ranks. A mixed burst whose new maximum arrives after the ranks are full shows whether all three ranks shift together. The all-maximum burst exposes a total that is too narrow, and an uneven total exposes rounding in the average. Directed runs then hold the results through idle cycles, hold `go` high through a run, and reset part-way through a run.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int RANKS = 3;

    typedef enum logic [1:0] {
        SEL_MAX  = 2'd0,
        SEL_MID  = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_MEAN = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } state_e;

endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic last_samp,
    output logic clr,
    output logic take,
    output logic run,
    output logic fin
);

    state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (go) st_d = ST_RUN;
            ST_RUN:  if (last_samp) st_d = ST_HOLD;
            ST_HOLD: if (go) st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign run  = (st_q == ST_RUN);
    assign take = run;
    assign clr  = go && !run;
    assign fin  = (st_q == ST_HOLD);

endmodule

// File: rtl/stat_rank.sv
module stat_rank
    import stat_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      take,
    input  logic [N-1:0]              din,
    output logic [RANKS-1:0][N-1:0]   rank_o
);

    logic [RANKS-1:0][N-1:0] rk_q;
    logic [RANKS-1:0][N-1:0] rk_d;
    logic [RANKS-1:0]        beats;

    // Ranks are kept in descending order, so beats[] is monotonic:
    // beating slot i implies beating every lower slot.
    for (genvar i = 0; i < RANKS; i++) begin : g_slot
        assign beats[i] = din > rk_q[i];
        if (i == 0) begin : g_top
            assign rk_d[i] = beats[i] ? din : rk_q[i];
        end else begin : g_lower
            assign rk_d[i] = beats[i-1] ? rk_q[i-1] :
                             beats[i]   ? din       : rk_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) rk_q <= '0;
        else if (take)  rk_q <= rk_d;
    end

    assign rank_o = rk_q;

endmodule

// File: rtl/stat_accum.sv
module stat_accum #(
    parameter int N = 8,
    parameter int M = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           take,
    input  logic [N-1:0]   din,
    output logic [N+M-1:0] sum_o,
    output logic           last_samp
);

    localparam int SW = N + M;
    localparam logic [M-1:0] CNT_LAST = {M{1'b1}};

    logic [SW-1:0] sum_q;
    logic [M-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            sum_q <= sum_q + {{M{1'b0}}, din};
            cnt_q <= cnt_q + M'(1);
        end
    end

    assign sum_o     = sum_q;
    assign last_samp = take && (cnt_q == CNT_LAST);

endmodule

// File: rtl/stat_top3_avg.sv
module stat_top3_avg
    import stat_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [N-1:0] din,
    input  logic [1:0]   sel,
    output logic         done,
    output logic [N-1:0] dout
);

    localparam int SW = N + M;

    logic                    clr_w, take_w, run_w, last_w;
    logic [SW-1:0]           sum_w;
    logic [RANKS-1:0][N-1:0] rank_w;
    logic [N-1:0]            mean_w;

    stat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .last_samp (last_w),
        .clr       (clr_w),
        .take      (take_w),
        .run       (run_w),
        .fin       (done)
    );

    stat_rank #(.N(N)) u_rank (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_w),
        .take   (take_w),
        .din    (din),
        .rank_o (rank_w)
    );

    stat_accum #(.N(N), .M(M)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_w),
        .take      (take_w),
        .din       (din),
        .sum_o     (sum_w),
        .last_samp (last_w)
    );

    assign mean_w = sum_w[SW-1:M];

    always_comb begin
        unique case (sel_e'(sel))
            SEL_MAX:  dout = rank_w[0];
            SEL_MID:  dout = rank_w[1];
            SEL_LOW:  dout = rank_w[2];
            SEL_MEAN: dout = mean_w;
            default:  dout = '0;
        endcase
    end

endmodule

// File: rtl/stat_chk.sv
module stat_chk
    import stat_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    go,
    input logic                    done,
    input logic                    run_w,
    input logic [N+M-1:0]          sum_w,
    input logic [RANKS-1:0][N-1:0] rank_w
);

    localparam int K = 1 << M;

    logic [M:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)                seen_q <= '0;
        else if (go && !run_w)  seen_q <= '0;
        else if (run_w)         seen_q <= seen_q + 1'b1;
    end

    // R4
    rank_order_chk: assert property (@(posedge clk) disable iff (rst)
        (rank_w[0] >= rank_w[1]) && (rank_w[1] >= rank_w[2]));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !run_w) |=> (sum_w == '0 && rank_w == '0 && !done));

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (seen_q == (M+1)'(K)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> (done && $stable(sum_w) && $stable(rank_w)));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!done && !run_w && sum_w == '0 && rank_w == '0));

endmodule

bind stat_top3_avg stat_chk #(.N(N), .M(M)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .done   (done),
    .run_w  (run_w),
    .sum_w  (sum_w),
    .rank_w (rank_w)
);

// File: tb/tb_stat_top3_avg.sv
module tb_stat_top3_avg;

    localparam int N = 8;
    localparam int M = 3;
    localparam int K = 1 << M;
    localparam int NV = 7;

    // per vector: K samples in arrival order, then largest, second, third, mean
    localparam logic [N-1:0] TBL_DIN [NV][K] = '{
        '{8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   8'd6,   8'd7, 8'd8},
        '{8'd8,   8'd7,   8'd6,   8'd5,   8'd4,   8'd3,   8'd2, 8'd1},
        '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0, 8'd0},
        '{8'd10,  8'd50,  8'd30,  8'd50,  8'd20,  8'd40,  8'd5, 8'd45},
        '{8'd7,   8'd7,   8'd7,   8'd3,   8'd9,   8'd1,   8'd2, 8'd0},
        '{8'd200, 8'd100, 8'd150, 8'd120, 8'd130, 8'd250, 8'd1, 8'd3}
    };
    localparam logic [N-1:0] TBL_EXP [NV][4] = '{
        '{8'd8,   8'd7,   8'd6,   8'd4},
        '{8'd8,   8'd7,   8'd6,   8'd4},
        '{8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd50,  8'd50,  8'd45,  8'd31},
        '{8'd9,   8'd7,   8'd7,   8'd4},
        '{8'd250, 8'd200, 8'd150, 8'd119}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [N-1:0] din = '0;
    logic [1:0]   sel = 2'd0;
    logic         done;
    logic [N-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stat_top3_avg #(.N(N), .M(M)) dut (
        .clk(clk), .rst(rst), .go(go), .din(din),
        .sel(sel), .done(done), .dout(dout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int vi);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #1;
            chk(req, int'(dout), int'(TBL_EXP[vi][s]));
        end
    endtask

    task automatic chk_zero(input string req);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #1;
            chk(req, int'(dout), 0);
        end
    endtask

    // go for one cycle, then K samples; optionally hold go high through the run
    task automatic run_vec(input int vi, input bit go_stuck);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = go_stuck;
        chk("R2 done low after start", int'(done), 0);
        sel = 2'd0;
        #1;
        chk("R2 largest cleared", int'(dout), 0);
        for (int i = 0; i < K; i++) begin
            din = TBL_DIN[vi][i];
            if (i == K - 1) chk("R3 done low before last sample", int'(done), 0);
            @(negedge clk);
        end
        go = 1'b0;
        chk("R3 done after k samples", int'(done), 1);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 done after reset", int'(done), 0);
        chk_zero("R1 dout after reset");

        // table walk: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            run_vec(v, 1'b0);
            chk_all("R4/R5/R6/R7/R8/R9 result", v);
        end

        // R10 hold while idle with changing din
        run_vec(6, 1'b0);
        for (int i = 0; i < 5; i++) begin
            din = 8'(8'hA5 + i * 37);
            @(negedge clk);
        end
        chk("R10 done held", int'(done), 1);
        chk_all("R10 results held", 6);

        // R10 go held during the run is ignored
        run_vec(4, 1'b1);
        chk_all("R10 go during run ignored", 4);

        // R11 reset in the middle of a run
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 3; i++) begin
            din = 8'd99;
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        din = 8'd77;
        repeat (K + 2) @(negedge clk);
        chk("R11 done after mid-run reset", int'(done), 0);
        chk_zero("R11 results after mid-run reset");

        // R3 a fresh run after reset still completes normally
        run_vec(0, 1'b0);
        chk_all("R3 run after abort", 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule